// File: doc/BRIEF.md
# Timer Capture, Compare and Pulse-Width Unit

This unit sits beside a free-running 16-bit timer and shares one 16-bit value register between three jobs. A 4-bit mode field chooses the job. In capture modes, edges on an input pin copy the timer into the value register. In compare modes, the timer is checked against the register on each timer step, and a hit drives the output pin or emits event pulses. In pulse-width mode, the unit produces a pulse-width output with a 10-bit duty setting that is held in a shadow copy until the next period boundary.

Software uses a plain single-cycle bus write port with four byte addresses: 0 control, 1 value low byte, 2 value high byte and 3 flag. A write is always taken in the cycle it is presented, so there is no back-pressure. Reads are combinational on `rd_addr`. The timer, the period register and any converter are outside the unit. The unit is told about timer steps through `tmr_tick`, about the two fractional prescaler bits through `tmr_pre`, and about period starts through `prd_start`.

Top module: `ccp_unit`

## Requirements
- R1: After reset, the control register, the value register and the flag all read 0, and `ccp_oe` and `ccp_out` are 0.
- R2: The control register holds the duty low bits in bits 5:4 and the mode in bits 3:0. Bits 7:6 always read 0, so a write of 0xFF reads back as 0x3F.
- R3: Mode codes 0000, 0001 and 0011 leave the unit idle. In these modes a match sets no flag, pin edges capture nothing, and `ccp_oe` is 0. A write of 0000 clears the capture prescaler and the pin latch.
- R4: Mode 0101 captures on each rising edge and mode 0100 on each falling edge of the synchronised `cap_pin`. A capture copies `tmr_val` into the value register and sets the flag. An edge of the other polarity does nothing.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. The edge counter clears whenever the mode changes.
- R6: In mode 0010, each compare match toggles `ccp_out` with `ccp_oe`=1 and sets the flag. Entering the mode starts the pin at 0.
- R7: Entering mode 1000 drives `ccp_out` low, and a match then forces it high. Entering mode 1001 drives it high, and a match forces it low. Both modes set the flag on a match.
- R8: Mode 1010 only sets the flag on a match. `ccp_oe` stays 0 and no pulse is emitted.
- R9: In mode 1011, a match sets the flag and pulses `tmr_rst_o` for one cycle. When `GEN_ADC_START`=1, `adc_go_o` pulses in the same cycle; otherwise it stays 0.
- R10: A match is evaluated only in cycles where `tmr_tick`=1, so a timer value that stays equal to the register produces no further events.
- R11: The flag is sticky. It clears only when address 3 is written with bit 0 = 0. A write with bit 0 = 1 leaves it unchanged, and a set in the same cycle as a clear wins.
- R12: Any mode 11xx is pulse-width mode. The duty is {value[7:0], control[5:4]}. On `prd_start`, `ccp_out` goes high, or stays low if the duty is 0. It goes low once {tmr_val[7:0], tmr_pre} ≥ duty.
- R13: The duty is loaded into its shadow copy only at `prd_start`, so a duty write in the middle of a period takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write address (0 ctrl, 1 low, 2 high, 3 flag) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| tmr_val | input | 16 | Timer count |
| tmr_pre | input | 2 | Timer fractional prescaler bits |
| tmr_tick | input | 1 | Timer stepped this cycle |
| prd_start | input | 1 | Pulse-width period boundary |
| cap_pin | input | 1 | Asynchronous capture pin |
| ccp_out | output | 1 | Output pin level |
| ccp_oe | output | 1 | Unit drives the pin |
| flag_o | output | 1 | Sticky event flag |
| tmr_rst_o | output | 1 | Timer reset pulse |
| adc_go_o | output | 1 | Converter start pulse |

## Verification
The bench targets the prescaled capture counts with directed pin pulses:
- It checks that the 4th edge, and not the 3rd, captures.
- It checks that a mode change partway through a count restarts it, so 15 edges after the change are not enough.

It holds the timer equal to the register without a tick. A design that matched on every cycle would raise the flag, or a timer-reset pulse, at this point.

It changes the duty in the middle of a period. An unbuffered design would move the falling edge in the current period.

It issues a flag clear in the same cycle as a match. A design that let the clear win would lose that event.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int TMR_W  = 16;
  localparam int DUTY_W = 10;

  typedef logic [3:0] mode_t;

  localparam mode_t MODE_OFF     = 4'b0000;
  localparam mode_t MODE_TOGGLE  = 4'b0010;
  localparam mode_t MODE_CAP_F   = 4'b0100;
  localparam mode_t MODE_CAP_R   = 4'b0101;
  localparam mode_t MODE_CAP_R4  = 4'b0110;
  localparam mode_t MODE_CAP_R16 = 4'b0111;
  localparam mode_t MODE_SET_HI  = 4'b1000;
  localparam mode_t MODE_SET_LO  = 4'b1001;
  localparam mode_t MODE_SOFT    = 4'b1010;
  localparam mode_t MODE_SPECIAL = 4'b1011;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  function automatic logic is_capture(mode_t m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_pwm(mode_t m);
    return m[3:2] == 2'b11;
  endfunction

  function automatic logic is_compare(mode_t m);
    return (m == MODE_TOGGLE) || (m[3:2] == 2'b10);
  endfunction

  function automatic logic drives_pin(mode_t m);
    return is_pwm(m) || m == MODE_TOGGLE || m == MODE_SET_HI || m == MODE_SET_LO;
  endfunction
endpackage

// File: rtl/ccp_capture.sv
module ccp_capture
  import ccp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode,
  input  logic  mode_chg,
  input  logic  pin_i,
  output logic  evt_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]  sh_q;
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;
  logic             rise, fall, qual, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], pin_i};
  end

  assign rise = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  assign fall = ~sh_q[SH_W-2] & sh_q[SH_W-1];

  always_comb begin
    case (mode)
      MODE_CAP_R4:  lim = PRE_W'(3);
      MODE_CAP_R16: lim = PRE_W'(15);
      default:      lim = '0;
    endcase
  end

  assign qual = is_capture(mode) && ((mode == MODE_CAP_F) ? fall : rise);
  assign last = (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (mode_chg || !is_capture(mode)) cnt_q <= '0;
    else if (qual)                          cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  assign evt_o = qual && last;
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
  import ccp_pkg::*;
#(
  parameter bit GEN_ADC_START = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode,
  input  mode_t            new_mode,
  input  logic             mode_load,
  input  logic             tick,
  input  logic [TMR_W-1:0] tmr,
  input  logic [TMR_W-1:0] ref_val,
  output logic             hit_o,
  output logic             pin_o,
  output logic             tmr_rst_o,
  output logic             adc_go_o
);
  logic pin_q, rst_q;

  assign hit_o = tick && (tmr == ref_val) && is_compare(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (mode_load) begin
      pin_q <= (new_mode == MODE_SET_LO);
    end else if (hit_o) begin
      case (mode)
        MODE_TOGGLE: pin_q <= ~pin_q;
        MODE_SET_HI: pin_q <= 1'b1;
        MODE_SET_LO: pin_q <= 1'b0;
        default:     pin_q <= pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= hit_o && (mode == MODE_SPECIAL);
  end

  assign pin_o     = pin_q;
  assign tmr_rst_o = rst_q;

  generate
    if (GEN_ADC_START) begin : g_adc
      assign adc_go_o = rst_q;
    end else begin : g_no_adc
      assign adc_go_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              prd_start,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DUTY_W-1:0] cnt_i,
  output logic              pin_o
);
  logic [DUTY_W-1:0] duty_q;
  logic              pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      pin_q  <= 1'b0;
    end else if (!en) begin
      duty_q <= '0;
      pin_q  <= 1'b0;
    end else if (prd_start) begin
      duty_q <= duty_i;
      pin_q  <= (duty_i != '0);
    end else if (cnt_i >= duty_q) begin
      pin_q  <= 1'b0;
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter bit GEN_ADC_START = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic [15:0] tmr_val,
  input  logic [1:0]  tmr_pre,
  input  logic        tmr_tick,
  input  logic        prd_start,
  input  logic        cap_pin,
  output logic        ccp_out,
  output logic        ccp_oe,
  output logic        flag_o,
  output logic        tmr_rst_o,
  output logic        adc_go_o
);
  mode_t            mode_q;
  logic [1:0]       dlo_q;
  logic [TMR_W-1:0] ccpr_q;
  logic             flag_q;

  logic ctrl_wr, mode_load, flag_clr;
  logic cap_evt, cmp_hit, cmp_pin, pwm_pin;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign mode_load = ctrl_wr && (wr_data[3:0] != mode_q);
  assign flag_clr  = wr_en && (wr_addr == ADDR_FLAG) && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      dlo_q  <= '0;
    end else if (ctrl_wr) begin
      mode_q <= wr_data[3:0];
      dlo_q  <= wr_data[5:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccpr_q <= '0;
    end else if (cap_evt) begin
      ccpr_q <= tmr_val;
    end else if (wr_en && wr_addr == ADDR_LO) begin
      ccpr_q[7:0] <= wr_data;
    end else if (wr_en && wr_addr == ADDR_HI) begin
      ccpr_q[15:8] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_q <= 1'b0;
    else if (cap_evt | cmp_hit) flag_q <= 1'b1;
    else if (flag_clr)          flag_q <= 1'b0;
  end

  ccp_capture #(.SYNC_STAGES(2), .PRE_W(4)) i_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .mode_chg (mode_load),
    .pin_i    (cap_pin),
    .evt_o    (cap_evt)
  );

  ccp_compare #(.GEN_ADC_START(GEN_ADC_START)) i_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .new_mode  (wr_data[3:0]),
    .mode_load (mode_load),
    .tick      (tmr_tick),
    .tmr       (tmr_val),
    .ref_val   (ccpr_q),
    .hit_o     (cmp_hit),
    .pin_o     (cmp_pin),
    .tmr_rst_o (tmr_rst_o),
    .adc_go_o  (adc_go_o)
  );

  ccp_pwm i_pwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (is_pwm(mode_q)),
    .prd_start (prd_start),
    .duty_i    ({ccpr_q[7:0], dlo_q}),
    .cnt_i     ({tmr_val[7:0], tmr_pre}),
    .pin_o     (pwm_pin)
  );

  assign ccp_oe  = drives_pin(mode_q);
  assign ccp_out = ccp_oe && (is_pwm(mode_q) ? pwm_pin : cmp_pin);
  assign flag_o  = flag_q;

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = {2'b00, dlo_q, mode_q};
      ADDR_LO:   rd_data = ccpr_q[7:0];
      ADDR_HI:   rd_data = ccpr_q[15:8];
      default:   rd_data = {7'd0, flag_q};
    endcase
  end
endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       tick,
  input logic       flag,
  input logic       pin,
  input logic       oe,
  input logic       tmr_rst,
  input logic       adc_go
);
  // R3
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] == 2'b00 && mode != 4'b0010) |-> !oe);

  // R9
  adc_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_go |-> tmr_rst);

  // R10
  rst_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst |-> $past(tick));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && wr_addr == 2'd3 && !wr_data[0])) |=> flag);

  // R7
  force_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'b1000 && pin && !(wr_en && wr_addr == 2'd0)) |=> pin);
endmodule

bind ccp_unit ccp_unit_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode_q),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .tick    (tmr_tick),
  .flag    (flag_o),
  .pin     (ccp_out),
  .oe      (ccp_oe),
  .tmr_rst (tmr_rst_o),
  .adc_go  (adc_go_o)
);

// File: tb/test_ccp_unit.sv
module test_ccp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] tmr_val = '0;
  logic [1:0]  tmr_pre = '0;
  logic        tmr_tick = 1'b0;
  logic        prd_start = 1'b0;
  logic        cap_pin = 1'b0;
  logic        ccp_out, ccp_oe, flag_o, tmr_rst_o, adc_go_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ccp_unit #(.GEN_ADC_START(1'b1)) i_ccp_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_val(tmr_val), .tmr_pre(tmr_pre),
    .tmr_tick(tmr_tick), .prd_start(prd_start), .cap_pin(cap_pin),
    .ccp_out(ccp_out), .ccp_oe(ccp_oe), .flag_o(flag_o),
    .tmr_rst_o(tmr_rst_o), .adc_go_o(adc_go_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic rd_val(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic set_val(input logic [15:0] v);
    bus_wr(2'd1, v[7:0]);
    bus_wr(2'd2, v[15:8]);
  endtask

  task automatic tick_at(input logic [15:0] v);
    @(negedge clk);
    tmr_val = v; tmr_tick = 1'b1;
    @(negedge clk);
    tmr_tick = 1'b0;
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk);
    cap_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic period;
    @(negedge clk);
    prd_start = 1'b1;
    @(negedge clk);
    prd_start = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [15:0] v;
    rd(2'd0, d);  check("R1 ctrl", 16'(d), 16'h0);
    rd_val(v);    check("R1 value", v, 16'h0);
    check("R1 flag", 16'(flag_o), 16'h0);
    check("R1 oe", 16'(ccp_oe), 16'h0);
    check("R1 out", 16'(ccp_out), 16'h0);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    bus_wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R2 readback", 16'(d), 16'h003F);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic t_idle;
    logic [15:0] v;
    logic [3:0] codes [3] = '{4'b0000, 4'b0001, 4'b0011};
    for (int i = 0; i < 3; i++) begin
      bus_wr(2'd0, {4'h0, codes[i]});
      set_val(16'h1234);
      tick_at(16'h1234);
      check("R3 no flag", 16'(flag_o), 16'h0);
      check("R3 no drive", 16'(ccp_oe), 16'h0);
      tmr_val = 16'h9999;
      pin_to(1'b1);
      pin_to(1'b0);
      rd_val(v); check("R3 no capture", v, 16'h1234);
    end
  endtask

  task automatic t_capture;
    logic [15:0] v;
    bus_wr(2'd0, 8'h05);
    tmr_val = 16'hABCD;
    pin_to(1'b1);
    rd_val(v); check("R4 rise capture", v, 16'hABCD);
    check("R4 rise flag", 16'(flag_o), 16'h1);
    bus_wr(2'd3, 8'h00);
    tmr_val = 16'h1111;
    pin_to(1'b0);
    rd_val(v); check("R4 fall ignored", v, 16'hABCD);
    check("R4 fall no flag", 16'(flag_o), 16'h0);
    bus_wr(2'd0, 8'h04);
    tmr_val = 16'h2222;
    pin_to(1'b1);
    rd_val(v); check("R4 rise ignored", v, 16'hABCD);
    pin_to(1'b0);
    rd_val(v); check("R4 fall capture", v, 16'h2222);
    check("R4 fall flag", 16'(flag_o), 16'h1);
    bus_wr(2'd3, 8'h00);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    bus_wr(2'd0, 8'h06);
    for (int i = 1; i <= 3; i++) begin
      tmr_val = 16'h0300 + 16'(i);
      pin_to(1'b1); pin_to(1'b0);
    end
    rd_val(v); check("R5 three edges", v, 16'h2222);
    check("R5 three no flag", 16'(flag_o), 16'h0);
    tmr_val = 16'h0304;
    pin_to(1'b1); pin_to(1'b0);
    rd_val(v); check("R5 fourth edge", v, 16'h0304);
    bus_wr(2'd3, 8'h00);
    pin_to(1'b1); pin_to(1'b0);
    pin_to(1'b1); pin_to(1'b0);
    bus_wr(2'd0, 8'h07);
    for (int i = 0; i < 15; i++) begin
      pin_to(1'b1); pin_to(1'b0);
    end
    check("R5 restart after change", 16'(flag_o), 16'h0);
    tmr_val = 16'h0716;
    pin_to(1'b1); pin_to(1'b0);
    rd_val(v); check("R5 sixteenth edge", v, 16'h0716);
    bus_wr(2'd3, 8'h00);
  endtask

  task automatic t_toggle;
    bus_wr(2'd0, 8'h02);
    set_val(16'h0050);
    check("R6 entry", 16'({ccp_oe, ccp_out}), 16'h2);
    tick_at(16'h0050);
    check("R6 toggle high", 16'(ccp_out), 16'h1);
    check("R6 flag", 16'(flag_o), 16'h1);
    tick_at(16'h0051);
    check("R6 no match", 16'(ccp_out), 16'h1);
    tick_at(16'h0050);
    check("R6 toggle low", 16'(ccp_out), 16'h0);
    bus_wr(2'd3, 8'h00);
  endtask

  task automatic t_force;
    bus_wr(2'd0, 8'h08);
    check("R7 entry low", 16'({ccp_oe, ccp_out}), 16'h2);
    tick_at(16'h0050);
    check("R7 forced high", 16'(ccp_out), 16'h1);
    check("R7 flag", 16'(flag_o), 16'h1);
    tick_at(16'h0050);
    check("R7 stays high", 16'(ccp_out), 16'h1);
    bus_wr(2'd0, 8'h09);
    check("R7 entry high", 16'(ccp_out), 16'h1);
    tick_at(16'h0050);
    check("R7 forced low", 16'(ccp_out), 16'h0);
    bus_wr(2'd3, 8'h00);
  endtask

  task automatic t_soft;
    bus_wr(2'd0, 8'h0A);
    tick_at(16'h0050);
    check("R8 flag", 16'(flag_o), 16'h1);
    check("R8 no drive", 16'(ccp_oe), 16'h0);
    check("R8 no pulse", 16'({tmr_rst_o, adc_go_o}), 16'h0);
    bus_wr(2'd3, 8'h00);
  endtask

  task automatic t_special;
    bus_wr(2'd0, 8'h0B);
    tick_at(16'h0050);
    check("R9 pulses", 16'({tmr_rst_o, adc_go_o}), 16'h3);
    check("R9 flag", 16'(flag_o), 16'h1);
    @(negedge clk);
    check("R9 one cycle", 16'({tmr_rst_o, adc_go_o}), 16'h0);
    bus_wr(2'd3, 8'h00);
  endtask

  task automatic t_tick_once;
    logic seen = 1'b0;
    @(negedge clk);
    tmr_val = 16'h0050;
    repeat (6) begin
      @(negedge clk);
      seen = seen | tmr_rst_o;
    end
    check("R10 no tick no flag", 16'(flag_o), 16'h0);
    check("R10 no tick no pulse", 16'(seen), 16'h0);
    tick_at(16'h0050);
    check("R10 tick fires", 16'(flag_o), 16'h1);
    bus_wr(2'd3, 8'h00);
  endtask

  task automatic t_flag;
    bus_wr(2'd0, 8'h0A);
    tick_at(16'h0050);
    bus_wr(2'd3, 8'h01);
    check("R11 write one keeps", 16'(flag_o), 16'h1);
    bus_wr(2'd3, 8'h00);
    check("R11 write zero clears", 16'(flag_o), 16'h0);
    @(negedge clk);
    tmr_val = 16'h0050; tmr_tick = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00;
    @(negedge clk);
    tmr_tick = 1'b0; wr_en = 1'b0;
    check("R11 set wins", 16'(flag_o), 16'h1);
    bus_wr(2'd3, 8'h00);
  endtask

  task automatic t_pwm;
    set_val(16'h0010);
    bus_wr(2'd0, 8'h1C);
    tmr_val = 16'h0000; tmr_pre = 2'd0;
    period;
    check("R12 high at start", 16'({ccp_oe, ccp_out}), 16'h3);
    @(negedge clk); tmr_val = 16'h0010;
    @(negedge clk);
    check("R12 below duty", 16'(ccp_out), 16'h1);
    tmr_pre = 2'd1;
    @(negedge clk);
    check("R12 reaches duty", 16'(ccp_out), 16'h0);
    tmr_val = 16'h0000; tmr_pre = 2'd0;
    set_val(16'h0000);
    bus_wr(2'd0, 8'h0C);
    period;
    check("R12 zero duty", 16'(ccp_out), 16'h0);
  endtask

  task automatic t_pwm_buf;
    set_val(16'h0020);
    tmr_val = 16'h0000;
    period;
    check("R13 high", 16'(ccp_out), 16'h1);
    set_val(16'h0004);
    @(negedge clk); tmr_val = 16'h0004;
    @(negedge clk);
    check("R13 old duty kept", 16'(ccp_out), 16'h1);
    tmr_val = 16'h0000;
    period;
    check("R13 new period high", 16'(ccp_out), 16'h1);
    tmr_val = 16'h0004;
    @(negedge clk);
    check("R13 new duty used", 16'(ccp_out), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ctrl;
    t_idle;
    t_capture;
    t_prescale;
    t_toggle;
    t_force;
    t_soft;
    t_special;
    bus_wr(2'd0, 8'h0B);
    t_tick_once;
    t_flag;
    t_pwm;
    t_pwm_buf;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule